// File: doc/BRIEF.md
# Boot Failure Supervisor

This block decides, on every boot, whether the system may keep running or must switch itself off. It watches two pieces of history: a sticky input that reports whether the last reset came from the watchdog, and a boot-attempt flag that it keeps in a register cleared only by a power-on reset. On each boot it first releases the power-hold pin and masks interrupts. It then stops and re-arms the watchdog with a 60 second load value, and only after that looks at the history.

If the reset did not come from the watchdog, or the flag is clear, the boot proceeds. The flag is set, the power hold is raised and interrupts are unmasked. Software that reaches a healthy state pulses a clear strobe to prove the boot worked. If the watchdog fired while the flag was still set, two attempts in a row have failed. The supervisor then clears the flag so that the next power-up starts fresh, keeps the power hold low, stops the watchdog and parks in a halt state. Only a power-on reset takes it out of that state.

Watchdog control is reduced to a command code and a load value. Pin multiplexing is outside the block.

Top module: `boot_sup`

## Requirements
- R1: While either reset is asserted, and in every cycle of a boot before the decision, `pwr_hold_o` is 0 and `irq_mask_o` is 1.
- R2: After the reset is released, the supervisor issues `wdt_cmd_o` = 1 (stop) for exactly one cycle, then `wdt_cmd_o` = 2 (start) for exactly one cycle with `wdt_load_o` = TIMEOUT_S × TICK_HZ (1966080 by default). Only then does it decide. In all other non-fatal cycles `wdt_cmd_o` is 0 (idle).
- R3: A boot with `wdt_cause_i` = 0 proceeds. `boot_ok_o` = 1, `pwr_hold_o` = 1, `irq_mask_o` = 0, and `flag_o` is 1 from the first cycle of that state.
- R4: A boot with `wdt_cause_i` = 1 and `flag_o` = 0 also proceeds, exactly as in R3.
- R5: A boot with `wdt_cause_i` = 1 and `flag_o` = 1 is fatal. The supervisor issues one more stop command, clears `flag_o`, and raises `halted_o`. From then on it keeps `pwr_hold_o` at 0, `irq_mask_o` at 1 and `wdt_cmd_o` at 0.
- R6: A one-cycle `sw_clear_i` pulse while `boot_ok_o` = 1 clears `flag_o`. `sw_clear_i` has no effect in any other state; in particular it cannot turn a fatal boot into a normal one.
- R7: `flag_o` keeps its value through a warm reset (`rst_n`) and is cleared only by `por_n`.
- R8: `halted_o` stays 1 through any warm reset, with no watchdog command issued, until `por_n` is asserted.
- R9: `boot_ok_o` and `halted_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| rst_n | input | 1 | Warm (watchdog or system) reset, asynchronous, active low; restarts the boot check |
| wdt_cause_i | input | 1 | Sticky indication that the last reset came from the watchdog |
| sw_clear_i | input | 1 | Software strobe that clears the boot-attempt flag |
| pwr_hold_o | output | 1 | Power-hold request; 1 keeps the supply on |
| irq_mask_o | output | 1 | Interrupt mask request; 1 while interrupts must stay off |
| wdt_cmd_o | output | 2 | Watchdog command: 0 idle, 1 stop, 2 start with load value |
| wdt_load_o | output | LOAD_W | Watchdog load value, nonzero only with the start command |
| boot_ok_o | output | 1 | Boot allowed to proceed |
| halted_o | output | 1 | Fatal failure, system parked |
| flag_o | output | 1 | Persistent boot-attempt flag |

## Verification
The bench goes after these cases:
- **Two-condition decision.** It pairs a watchdog cause with a clear flag and a no-watchdog cause with a set flag. A design that decided on either condition alone would halt on the first failure, or would never halt.
- **Clear strobe held through a fatal boot.** A design that accepted the clear outside the running state would let the boot proceed instead of halting.
- **Warm reset while halted, and warm reset with the flag set.** A design that reset the flag or the halt state with the warm reset would restart the boot cycle forever and never power down.
- **Watchdog command order and count.** A reordered or missing stop, or a wrong load value, shows up as a wrong command count or value seen at the ports.

// File: rtl/boot_sup_pkg.sv
package boot_sup_pkg;

  typedef enum logic [2:0] {
    ST_SAFE  = 3'd0,
    ST_WDOFF = 3'd1,
    ST_ARM   = 3'd2,
    ST_CHECK = 3'd3,
    ST_RUN   = 3'd4,
    ST_FAIL  = 3'd5,
    ST_HALT  = 3'd6
  } sup_state_e;

  localparam logic [1:0] WD_IDLE  = 2'd0;
  localparam logic [1:0] WD_STOP  = 2'd1;
  localparam logic [1:0] WD_START = 2'd2;

endpackage

// File: rtl/boot_sup_rst_sync.sv
module boot_sup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/boot_sup_sticky.sv
module boot_sup_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic en;
  logic d;

  always_comb begin
    en = set_i | clr_i;
    d  = ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else if (en) begin
      q_o <= d;
    end
  end

endmodule

// File: rtl/boot_sup_seq.sv
module boot_sup_seq
  import boot_sup_pkg::*;
#(
  parameter int              LOAD_W   = 24,
  parameter logic [LOAD_W-1:0] LOAD_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_q_i,
  input  logic              flag_q_i,
  input  logic              wdt_cause_i,
  input  logic              sw_clear_i,
  output logic              pwr_hold_o,
  output logic              irq_mask_o,
  output logic [1:0]        wdt_cmd_o,
  output logic [LOAD_W-1:0] wdt_load_o,
  output logic              boot_ok_o,
  output logic              flag_set_o,
  output logic              flag_clr_o,
  output logic              halt_set_o
);

  sup_state_e state_q;
  sup_state_e state_d;
  logic       fatal;

  assign fatal = wdt_cause_i & flag_q_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SAFE:  state_d = halt_q_i ? ST_HALT : ST_WDOFF;
      ST_WDOFF: state_d = ST_ARM;
      ST_ARM:   state_d = ST_CHECK;
      ST_CHECK: state_d = fatal ? ST_FAIL : ST_RUN;
      ST_RUN:   state_d = ST_RUN;
      ST_FAIL:  state_d = ST_HALT;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_SAFE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SAFE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    pwr_hold_o = (state_q == ST_RUN);
    irq_mask_o = (state_q != ST_RUN);
    boot_ok_o  = (state_q == ST_RUN);
    wdt_cmd_o  = WD_IDLE;
    wdt_load_o = '0;
    if ((state_q == ST_WDOFF) || (state_q == ST_FAIL)) begin
      wdt_cmd_o = WD_STOP;
    end else if (state_q == ST_ARM) begin
      wdt_cmd_o  = WD_START;
      wdt_load_o = LOAD_VAL;
    end
    flag_set_o = (state_q == ST_CHECK) & ~fatal;
    flag_clr_o = (state_q == ST_FAIL) | ((state_q == ST_RUN) & sw_clear_i);
    halt_set_o = (state_q == ST_FAIL);
  end

endmodule

// File: rtl/boot_sup.sv
module boot_sup #(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_S   = 60,
  parameter int TICK_HZ     = 32768,
  parameter int LOAD_W      = 24
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wdt_cause_i,
  input  logic              sw_clear_i,
  output logic              pwr_hold_o,
  output logic              irq_mask_o,
  output logic [1:0]        wdt_cmd_o,
  output logic [LOAD_W-1:0] wdt_load_o,
  output logic              boot_ok_o,
  output logic              halted_o,
  output logic              flag_o
);

  localparam logic [LOAD_W-1:0] LOAD_VAL = LOAD_W'(TIMEOUT_S * TICK_HZ);

  logic por_rst_n;
  logic core_rst_n;
  logic warm_arst_n;
  logic flag_set;
  logic flag_clr;
  logic halt_set;

  assign warm_arst_n = por_n & rst_n;

  boot_sup_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk     (clk),
    .arst_n  (por_n),
    .rst_n_o (por_rst_n)
  );

  boot_sup_rst_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
    .clk     (clk),
    .arst_n  (warm_arst_n),
    .rst_n_o (core_rst_n)
  );

  boot_sup_seq #(
    .LOAD_W   (LOAD_W),
    .LOAD_VAL (LOAD_VAL)
  ) u_seq (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .halt_q_i    (halted_o),
    .flag_q_i    (flag_o),
    .wdt_cause_i (wdt_cause_i),
    .sw_clear_i  (sw_clear_i),
    .pwr_hold_o  (pwr_hold_o),
    .irq_mask_o  (irq_mask_o),
    .wdt_cmd_o   (wdt_cmd_o),
    .wdt_load_o  (wdt_load_o),
    .boot_ok_o   (boot_ok_o),
    .flag_set_o  (flag_set),
    .flag_clr_o  (flag_clr),
    .halt_set_o  (halt_set)
  );

  boot_sup_sticky u_flag (
    .clk   (clk),
    .rst_n (por_rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_o)
  );

  boot_sup_sticky u_halt (
    .clk   (clk),
    .rst_n (por_rst_n),
    .set_i (halt_set),
    .clr_i (1'b0),
    .q_o   (halted_o)
  );

endmodule

// File: rtl/boot_sup_chk.sv
module boot_sup_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       sw_clear_i,
  input logic       pwr_hold_o,
  input logic       irq_mask_o,
  input logic [1:0] wdt_cmd_o,
  input logic       boot_ok_o,
  input logic       halted_o,
  input logic       flag_o
);

  // R1: reset forces the safe output pair
  a_r1_reset_safe: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |-> (!pwr_hold_o && irq_mask_o));

  // R2: a start command always follows a stop command
  a_r2_stop_then_start: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wdt_cmd_o == 2'd2) |-> ($past(wdt_cmd_o) == 2'd1));

  // R3: entering the running state finds the flag already set
  a_r3_flag_on_run: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(boot_ok_o) |-> flag_o);

  // R5: a halted system holds power off and sends no watchdog command
  a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!por_n)
    halted_o |-> (!pwr_hold_o && irq_mask_o && (wdt_cmd_o == 2'd0)));

  // R6: the flag falls only on a clear while running or on entering halt
  a_r6_flag_fall: assert property (@(posedge clk) disable iff (!por_n)
    $fell(flag_o) |-> ($past(sw_clear_i && boot_ok_o) || halted_o));

  // R8: halt persists until power-on reset
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!por_n)
    halted_o |=> halted_o);

  // R9: running and halted exclude each other
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!por_n)
    !(boot_ok_o && halted_o));

endmodule

bind boot_sup boot_sup_chk u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .sw_clear_i (sw_clear_i),
  .pwr_hold_o (pwr_hold_o),
  .irq_mask_o (irq_mask_o),
  .wdt_cmd_o  (wdt_cmd_o),
  .boot_ok_o  (boot_ok_o),
  .halted_o   (halted_o),
  .flag_o     (flag_o)
);

// File: tb/boot_sup_tb.sv
`timescale 1ns/1ps
module boot_sup_tb;

  localparam int LOAD_W  = 24;
  localparam int EXP_LOAD = 60 * 32768;

  logic              clk;
  logic              por_n;
  logic              rst_n;
  logic              wdt_cause_i;
  logic              sw_clear_i;
  logic              pwr_hold_o;
  logic              irq_mask_o;
  logic [1:0]        wdt_cmd_o;
  logic [LOAD_W-1:0] wdt_load_o;
  logic              boot_ok_o;
  logic              halted_o;
  logic              flag_o;

  int n_checks;
  int n_fail;
  int cycles;
  bit m_flag;
  bit m_halt;

  boot_sup u_dut (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .wdt_cause_i (wdt_cause_i),
    .sw_clear_i  (sw_clear_i),
    .pwr_hold_o  (pwr_hold_o),
    .irq_mask_o  (irq_mask_o),
    .wdt_cmd_o   (wdt_cmd_o),
    .wdt_load_o  (wdt_load_o),
    .boot_ok_o   (boot_ok_o),
    .halted_o    (halted_o),
    .flag_o      (flag_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_fatal(input bit cause, input bit flag);
    return cause & flag;
  endfunction

  // One boot: assert a reset, then watch the ports until a decision
  task automatic run_boot(input bit use_por, input bit cause, input bit hold_clr);
    int  n_stop, n_start;
    bit  pre_bad, load_bad, order_bad, got_ok, got_halt;
    bit  was_halt, fatal;
    @(negedge clk);
    if (use_por) por_n = 1'b0; else rst_n = 1'b0;
    wdt_cause_i = cause;
    sw_clear_i  = hold_clr;
    if (use_por) begin
      m_flag = 1'b0;
      m_halt = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(!pwr_hold_o && irq_mask_o, "R1 reset safe outputs", {pwr_hold_o, irq_mask_o}, 1);
    check(flag_o == m_flag, "R7 flag through reset", flag_o, m_flag);
    check(halted_o == m_halt, "R8 halt through reset", halted_o, m_halt);
    was_halt = m_halt;
    fatal    = !was_halt && exp_fatal(cause, m_flag);
    por_n = 1'b1;
    rst_n = 1'b1;
    n_stop = 0; n_start = 0;
    pre_bad = 0; load_bad = 0; order_bad = 0; got_ok = 0; got_halt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (boot_ok_o) begin got_ok = 1; break; end
      if (halted_o) begin got_halt = 1; break; end
      if (pwr_hold_o || !irq_mask_o) pre_bad = 1;
      if (wdt_cmd_o == 2'd1) n_stop++;
      if (wdt_cmd_o == 2'd2) begin
        n_start++;
        if (n_stop == 0) order_bad = 1;
        if (wdt_load_o != LOAD_W'(EXP_LOAD)) load_bad = 1;
      end
    end
    sw_clear_i = 1'b0;
    check(!pre_bad, "R1 safe outputs before decision", pre_bad, 0);
    check(!order_bad && !load_bad, "R2 stop before start with load", {order_bad, load_bad}, 0);
    if (was_halt) begin
      check(got_halt && !got_ok, "R8 stays halted after warm reset", got_halt, 1);
      check(n_stop == 0 && n_start == 0, "R8 no watchdog command", n_stop + n_start, 0);
    end else if (fatal) begin
      check(got_halt && !got_ok, "R5 fatal boot halts", got_halt, 1);
      check(n_stop == 2 && n_start == 1, "R5 extra stop command", n_stop, 2);
      check(flag_o == 1'b0, "R5 flag cleared on halt", flag_o, 0);
      if (hold_clr) check(got_halt, "R6 clear ignored before run", got_halt, 1);
      m_flag = 1'b0;
      m_halt = 1'b1;
    end else begin
      check(got_ok && !got_halt, cause ? "R4 watchdog cause with clear flag proceeds"
                                       : "R3 normal cause proceeds", got_ok, 1);
      check(n_stop == 1 && n_start == 1, "R2 one stop one start", n_stop * 10 + n_start, 11);
      check(pwr_hold_o && !irq_mask_o, "R3 run outputs", {pwr_hold_o, irq_mask_o}, 2);
      check(flag_o == 1'b1, "R3 flag set on run", flag_o, 1);
      m_flag = 1'b1;
    end
    if (got_halt) begin
      repeat (3) begin
        @(negedge clk);
        check(halted_o && !boot_ok_o && !pwr_hold_o && wdt_cmd_o == 2'd0,
              "R9 halt quiet and exclusive", {halted_o, boot_ok_o, pwr_hold_o}, 4);
      end
    end
  endtask

  task automatic pulse_clear();
    sw_clear_i = 1'b1;
    @(negedge clk);
    sw_clear_i = 1'b0;
    check(flag_o == 1'b0, "R6 clear while running", flag_o, 0);
    check(boot_ok_o == 1'b1, "R9 still running after clear", boot_ok_o, 1);
    m_flag = 1'b0;
  endtask

  initial begin
    n_checks = 0; n_fail = 0; cycles = 0;
    m_flag = 0; m_halt = 0;
    void'($urandom(32'd20240917));
    por_n = 1'b0; rst_n = 1'b0; wdt_cause_i = 1'b0; sw_clear_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!pwr_hold_o && irq_mask_o && wdt_cmd_o == 2'd0 && !boot_ok_o && !halted_o && !flag_o,
          "R1 power-on reset state", {pwr_hold_o, irq_mask_o, boot_ok_o, halted_o, flag_o}, 8);

    // Directed corner cases
    run_boot(1'b1, 1'b0, 1'b0);   // R3 cold boot
    pulse_clear();                // R6
    run_boot(1'b0, 1'b1, 1'b0);   // R4 watchdog cause, flag clear
    run_boot(1'b0, 1'b0, 1'b0);   // R3/R7 flag set, normal cause
    run_boot(1'b0, 1'b1, 1'b1);   // R5/R6 fatal despite held clear
    run_boot(1'b0, 1'b0, 1'b0);   // R8 warm reset while halted
    run_boot(1'b1, 1'b1, 1'b0);   // R7 power-on clears flag, boot proceeds

    // Random sequence
    for (int k = 0; k < 60; k++) begin
      bit use_por;
      use_por = m_halt ? ($urandom % 2 == 0) : ($urandom % 8 == 0);
      run_boot(use_por, 1'($urandom % 2), ($urandom % 4 == 0));
      if (boot_ok_o && ($urandom % 2 == 0)) pulse_clear();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule